// File: doc/BRIEF.md
# Programmable Input Persistency Filter

This block cleans up two slow digital status inputs, A and B, before they reach an interrupt controller. Each raw input first passes through a two-stage synchroniser. A shared prescaler then produces a sample strobe every `SAMPLE_DIV` system clocks, which is 32 µs at the intended clock rate. On each strobe, every channel compares its synchronised input with its current filtered level. A difference must persist for a programmed number of consecutive samples before the filtered level follows it. A shorter excursion is dropped without any trace.

Each channel has its own 8-bit duration setting, counted in units of two samples (64 µs). The required run is therefore twice the programmed value. A setting of zero turns the filter off: the first sample that sees a difference is accepted at once. Whenever a filtered level flips, the channel raises a single-cycle event strobe, which the interrupt logic can latch.

Top module: `persist_filter`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, both filtered levels and both event strobes are 0.
- R2: With a duration of 0 on a channel, the filtered level takes the new input value on the first sample strobe that sees the change. Sample strobes occur on every `SAMPLE_DIV`-th clock edge after reset release. The level changes on no other edge.
- R3: With a duration N in 1..255, the filtered level flips on the sample edge at which the input has differed from it for 2·N consecutive samples. After 2·N−1 such samples it has not yet flipped.
- R4: If the input returns to the filtered level before 2·N differing samples, no flip and no event occur. The run count restarts, so a later change again needs a full 2·N samples.
- R5: Each flip of a filtered level raises that channel's event bit for exactly one cycle. The event is high in the same cycle the new level first appears, and at no other time.
- R6: The two channels are independent. Bit 0 of each vector port is channel A and bit 1 is channel B. `dur_cfg_i[7:0]` sets the duration of A and `dur_cfg_i[15:8]` sets the duration of B.
- R7: The largest duration, 255, requires 510 consecutive differing samples.
- R8: An input pulse that starts and ends between two sample strobes is never seen, even with a duration of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| in_raw_i | input | NUM_IN (2) | Asynchronous raw inputs; bit 0 is A, bit 1 is B |
| dur_cfg_i | input | NUM_IN*8 (16) | Per-channel persistency duration in 64 µs units |
| filt_lvl_o | output | NUM_IN (2) | Filtered input levels |
| filt_evt_o | output | NUM_IN (2) | One-cycle strobe on each filtered level change |

## Verification
The assertions take for granted that `SAMPLE_DIV` is at least 2, so that sample strobes are never on adjacent cycles. They also assume reset is driven low from time zero. They do not depend on the input pattern or on the duration values. The stimulus changes durations only while the affected input matches its filtered level. This makes every flip time predictable from the requirement arithmetic alone. Raw input changes are made on the falling edge just after a sample edge, so the synchroniser delay always settles well before the next strobe.

// File: rtl/pf_pkg.sv
package pf_pkg;
    localparam int unsigned DUR_W = 8;
    localparam int unsigned RUN_W = DUR_W + 1;

    typedef logic [DUR_W-1:0] dur_t;
    typedef logic [RUN_W-1:0] run_t;

    typedef struct packed {
        logic level;
        logic evt;
        run_t run;
    } chan_st_t;

    // number of 32 us samples a change must persist: two per 64 us unit
    function automatic run_t run_target(input dur_t d);
        return {d, 1'b0};
    endfunction
endpackage

// File: rtl/pf_tick.sv
module pf_tick #(
    parameter int unsigned SAMPLE_DIV = 4000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int unsigned CW = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(SAMPLE_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick_o = (cnt_q == LAST);

    always_comb begin
        cnt_d = tick_o ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pf_sync.sv
module pf_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/pf_chan.sv
module pf_chan
    import pf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic samp_i,
    input  dur_t dur_i,
    output logic level_o,
    output logic evt_o
);
    chan_st_t st_d, st_q;
    logic     differs;
    logic     bypass;
    run_t     run_inc;
    logic     run_done;

    assign differs  = (samp_i != st_q.level);
    assign bypass   = (dur_i == '0);
    assign run_inc  = st_q.run + 1'b1;
    // >= keeps the run bounded if the duration is lowered mid-run (R3)
    assign run_done = (run_inc >= run_target(dur_i));

    always_comb begin
        st_d     = st_q;
        st_d.evt = 1'b0;
        if (tick_i) begin
            if (differs) begin
                if (bypass || run_done) begin
                    st_d.level = ~st_q.level;   // R2 / R3 accept
                    st_d.evt   = 1'b1;          // R5 strobe
                    st_d.run   = '0;
                end else begin
                    st_d.run   = run_inc;
                end
            end else begin
                st_d.run = '0;                  // R4 restart on return
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;                 // R1
        else        st_q <= st_d;
    end

    assign level_o = st_q.level;
    assign evt_o   = st_q.evt;
endmodule

// File: rtl/persist_filter.sv
module persist_filter
    import pf_pkg::*;
#(
    parameter int unsigned NUM_IN      = 2,
    parameter int unsigned SAMPLE_DIV  = 4000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_IN-1:0]       in_raw_i,
    input  logic [NUM_IN*DUR_W-1:0] dur_cfg_i,
    output logic [NUM_IN-1:0]       filt_lvl_o,
    output logic [NUM_IN-1:0]       filt_evt_o
);
    logic              tick_w;
    logic [NUM_IN-1:0] samp_w;

    pf_tick #(.SAMPLE_DIV(SAMPLE_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick_w)
    );

    // R6: one synchroniser and one filter per input
    for (genvar i = 0; i < NUM_IN; i++) begin : g_ch
        pf_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d_i   (in_raw_i[i]),
            .q_o   (samp_w[i])
        );

        pf_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_i  (tick_w),
            .samp_i  (samp_w[i]),
            .dur_i   (dur_cfg_i[i*DUR_W +: DUR_W]),
            .level_o (filt_lvl_o[i]),
            .evt_o   (filt_evt_o[i])
        );
    end
endmodule

// File: rtl/persist_filter_chk.sv
module persist_filter_chk #(
    parameter int unsigned NUM_IN = 2,
    parameter int unsigned DUR_W  = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    tick,
    input logic [NUM_IN-1:0]       samp,
    input logic [NUM_IN*DUR_W-1:0] dur,
    input logic [NUM_IN-1:0]       lvl,
    input logic [NUM_IN-1:0]       evt
);
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (lvl == '0 && evt == '0));

    for (genvar i = 0; i < NUM_IN; i++) begin : g_p
        p_move_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(tick) |-> $stable(lvl[i]));

        p_bypass_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(tick) && $past(dur[i*DUR_W +: DUR_W] == '0) &&
             $past(samp[i] != lvl[i])) |-> (lvl[i] != $past(lvl[i])));

        p_evt_means_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
            evt[i] |-> (lvl[i] != $past(lvl[i])));

        p_flip_means_evt_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (lvl[i] != $past(lvl[i])) |-> evt[i]);

        p_evt_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
            evt[i] |=> !evt[i]);
    end
endmodule

bind persist_filter persist_filter_chk #(.NUM_IN(NUM_IN), .DUR_W(pf_pkg::DUR_W)) chk_i (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick_w),
    .samp (samp_w),
    .dur  (dur_cfg_i),
    .lvl  (filt_lvl_o),
    .evt  (filt_evt_o)
);

// File: tb/persist_filter_tb_top.sv
module persist_filter_tb_top;
    localparam int DIV = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  raw = '0;
    logic [15:0] dur = '0;
    logic [1:0]  lvl, evt;

    int checks = 0;
    int errors = 0;
    int tb_cyc = 0;
    int ev_cnt [2] = '{0, 0};
    bit done = 0;
    logic exp_a = 1'b0;

    always #4 clk = ~clk;

    persist_filter #(.NUM_IN(2), .SAMPLE_DIV(DIV)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_raw_i  (raw),
        .dur_cfg_i (dur),
        .filt_lvl_o(lvl),
        .filt_evt_o(evt)
    );

    always @(posedge clk) begin
        if (!rst_n) tb_cyc <= 0;
        else        tb_cyc <= tb_cyc + 1;
        if (evt[0]) ev_cnt[0] <= ev_cnt[0] + 1;
        if (evt[1]) ev_cnt[1] <= ev_cnt[1] + 1;
    end

    typedef struct packed {
        logic [7:0] d;
        logic [9:0] hold;
        logic       flip;
    } vec_t;

    // duration, samples held, flip expected
    localparam vec_t VECS [8] = '{
        '{8'd0, 10'd1,  1'b1},
        '{8'd1, 10'd2,  1'b1},
        '{8'd1, 10'd1,  1'b0},
        '{8'd3, 10'd5,  1'b0},
        '{8'd3, 10'd6,  1'b1},
        '{8'd5, 10'd10, 1'b1},
        '{8'd2, 10'd3,  1'b0},
        '{8'd4, 10'd8,  1'b1}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic to_phase();
        @(negedge clk);
        while (tb_cyc % DIV != 0) @(negedge clk);
    endtask

    task automatic wait_neg(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int e0;
        int e1;
        wait_neg(3);
        chk(lvl == 2'b00 && evt == 2'b00, "R1 reset", lvl, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(lvl == 2'b00 && evt == 2'b00, "R1 after release", lvl, 0);

        // vector walk on channel A; B holds 0 with a nonzero duration
        dur[15:8] = 8'd7;
        for (int v = 0; v < 8; v++) begin
            dur[7:0] = VECS[v].d;
            to_phase();
            e0 = ev_cnt[0];
            raw[0] = ~exp_a;
            if (VECS[v].flip) begin
                wait_neg(int'(VECS[v].hold) * DIV - 1);
                chk(lvl[0] == exp_a, "R3 not one edge early", lvl[0], exp_a);
                @(negedge clk);
                chk(lvl[0] == ~exp_a, "R2/R3 flip at 2N samples", lvl[0], ~exp_a);
                chk(evt[0] == 1'b1, "R5 event with flip", evt[0], 1);
                @(negedge clk);
                chk(evt[0] == 1'b0, "R5 event one cycle", evt[0], 0);
                exp_a = ~exp_a;
                wait_neg(DIV);
                chk(ev_cnt[0] - e0 == 1, "R5 one event per flip", ev_cnt[0] - e0, 1);
            end else begin
                wait_neg(int'(VECS[v].hold) * DIV);
                raw[0] = exp_a;          // R4 return before run completes
                wait_neg(2 * DIV);
                chk(lvl[0] == exp_a, "R4 glitch rejected", lvl[0], exp_a);
                chk(ev_cnt[0] - e0 == 0, "R4 no event", ev_cnt[0] - e0, 0);
            end
            chk(lvl[1] == 1'b0, "R6 B untouched", lvl[1], 0);
        end

        // R8: short pulse between strobes, bypass duration
        dur[7:0] = 8'd0;
        to_phase();
        e0 = ev_cnt[0];
        raw[0] = ~exp_a;
        wait_neg(2);
        raw[0] = exp_a;
        wait_neg(2 * DIV);
        chk(lvl[0] == exp_a, "R8 pulse between samples", lvl[0], exp_a);
        chk(ev_cnt[0] - e0 == 0, "R8 no event", ev_cnt[0] - e0, 0);

        // R6: both channels together with different durations
        dur = {8'd5, 8'd2};
        to_phase();
        e0 = ev_cnt[0];
        e1 = ev_cnt[1];
        raw = {1'b1, ~exp_a};
        wait_neg(4 * DIV);
        chk(lvl[0] == ~exp_a, "R6 A flips at 4 samples", lvl[0], ~exp_a);
        chk(lvl[1] == 1'b0, "R6 B still waiting", lvl[1], 0);
        exp_a = ~exp_a;
        wait_neg(6 * DIV);
        chk(lvl[1] == 1'b1, "R6 B flips at 10 samples", lvl[1], 1);
        wait_neg(2);
        chk(ev_cnt[0] - e0 == 1, "R6 A one event", ev_cnt[0] - e0, 1);
        chk(ev_cnt[1] - e1 == 1, "R6 B one event", ev_cnt[1] - e1, 1);

        // R7: largest duration on B
        dur[15:8] = 8'd255;
        to_phase();
        raw[1] = 1'b0;
        wait_neg(510 * DIV - 1);
        chk(lvl[1] == 1'b1, "R7 held at 509 samples", lvl[1], 1);
        @(negedge clk);
        chk(lvl[1] == 1'b0, "R7 flip at 510 samples", lvl[1], 0);

        // R1: reset mid-run clears a high level
        dur[7:0] = 8'd0;
        to_phase();
        raw[0] = 1'b1;
        wait_neg(2 * DIV);
        chk(lvl[0] == 1'b1, "R2 bypass accept", lvl[0], 1);
        rst_n = 1'b0;
        raw = 2'b00;
        wait_neg(2);
        chk(lvl == 2'b00 && evt == 2'b00, "R1 reset mid-run", lvl, 0);
        rst_n = 1'b1;
        wait_neg(2 * DIV);
        chk(lvl == 2'b00, "R1 stays clear", lvl, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule